// File: doc/BRIEF.md
# Two-Stage FSK Tone-to-Bit Demodulator

This block turns a sliced two-tone audio square wave, as recorded on a cassette data tape, into a serial logic level of the kind a UART receiver expects. The carrier alternates between a fast tone at 2400 Hz, which stands for a logic 1 and is also what an idle line carries, and a slow tone at 1200 Hz, which stands for a logic 0. The output idles high, and a start bit shows up as a falling level.

Frequency is told apart by two retriggerable one-shot timers in series. No period counter and no correlator is used. The first timer is cleared while the input is high and times how long the input stays low. Each low half of the slow tone lasts about 416 µs and outlasts the 300 µs threshold, so the first timer emits a one-clock pulse. Each low half of the fast tone lasts about 208 µs and ends before the threshold. The second timer is reloaded by every such pulse and holds for about 1100 µs. This is longer than the roughly 832 µs between pulses of the slow tone, so the serial level stays low for as long as the slow tone lasts. It returns high once the pulses stop. The raw input passes through a flip-flop synchronizer first. Both timeouts are given in microseconds and converted to clock cycles from a clock-frequency parameter.

Top module: `fsk_tone_demod`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `bit_out` is 1 and `pulse_dbg` is 0.
- R2: `pulse_dbg` rises only after the synchronized input has been low for LOW_US worth of clock cycles. At a 1 MHz clock this is 300 cycles. A low interval of 290 cycles gives no pulse, and one of 320 cycles gives exactly one.
- R3: Every `pulse_dbg` pulse lasts exactly one clock cycle.
- R4: A single uninterrupted low interval gives at most one pulse, however long it lasts, because the low-time count saturates. After a 3000-cycle low, `bit_out` has returned to 1 while the input is still low.
- R5: A 2400 Hz tone, with low halves of about 208 µs, produces no pulses, and `bit_out` stays 1 throughout.
- R6: A 1200 Hz tone produces one pulse per tone cycle. From about LOW_US plus three cycles after the burst starts until the burst ends, `bit_out` is 0 without a break.
- R7: `bit_out` is 0 during the HOLD_US worth of cycles that follow each pulse. It is 1 from the next cycle on if no further pulse has arrived, so the line returns high about 570 cycles after a slow-tone burst ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, CLK_HZ |
| rst_n | input | 1 | Synchronous reset, active low |
| tone_in | input | 1 | Sliced tone square wave, asynchronous |
| bit_out | output | 1 | Demodulated serial level: 1 for the fast tone, 0 for the slow tone |
| pulse_dbg | output | 1 | First-stage one-cycle pulse train, for debugging |

## Verification
The bench drives alternating fast-tone and slow-tone segments shaped like a serial frame: idle, a start bit, a mark bit, three space bits and idle again. This separates a correct mapping from swapped tones and from a hold too short to bridge the gaps between pulses. Isolated low intervals of 290 and 320 cycles bracket the first-stage threshold. A 3000-cycle low exposes a count that wraps instead of saturating, or a hold that never expires. Pulses are counted for each segment, so a doubled or missing pulse shows up even when the serial level happens to look right. A reset applied in the middle of a slow-tone bit must return the line high at once.

// File: rtl/fsk_demod_pkg.sv
// Package: shared helpers for the two-stage FSK demodulator.
// Assumes clock frequencies in Hz and timeouts in whole microseconds.
package fsk_demod_pkg;

    // Convert a time in microseconds to clock cycles at clk_hz, rounded, never below 1.
    function automatic int unsigned us_to_cycles(input longint unsigned clk_hz,
                                                 input int unsigned us);
        longint unsigned prod;
        prod = (clk_hz * longint'(us) + 64'd500000) / 64'd1000000;
        if (prod == 0) begin
            prod = 1;
        end
        return int'(prod);
    endfunction

    // Counter width able to hold values 0..max_val.
    function automatic int unsigned cnt_width(input int unsigned max_val);
        int unsigned w;
        w = $clog2(max_val + 1);
        if (w == 0) begin
            w = 1;
        end
        return w;
    endfunction

endpackage

// File: rtl/fsk_in_sync.sv
// Module: fsk_in_sync
// Brings the asynchronous tone input into the clock domain through a chain
// of STAGES flip-flops. Assumes STAGES >= 2. Reset loads the idle level
// (high), so the low-time timer downstream starts out cleared.
module fsk_in_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] chain_q;

    generate
        genvar gi;
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                // Capture the raw input into the first stage.
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        chain_q[0] <= 1'b1;
                    end else begin
                        chain_q[0] <= async_in;
                    end
                end
            end else begin : g_next
                // Shift the previous stage forward.
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        chain_q[gi] <= 1'b1;
                    end else begin
                        chain_q[gi] <= chain_q[gi-1];
                    end
                end
            end
        end
    endgenerate

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/fsk_low_timer.sv
// Module: fsk_low_timer
// First stage. A one-shot held clear while the synchronized input is high.
// It counts consecutive low cycles and emits a one-cycle pulse on the cycle
// the count reaches LOW_CYC. The count then saturates, so one low interval
// fires at most once. Assumes LOW_CYC >= 1.
module fsk_low_timer #(
    parameter int unsigned LOW_CYC = 300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_in,
    output logic fire_o
);

    import fsk_demod_pkg::*;

    localparam int unsigned CW = cnt_width(LOW_CYC);
    localparam logic [CW-1:0] LIMIT  = CW'(LOW_CYC);
    localparam logic [CW-1:0] ARMPNT = CW'(LOW_CYC - 1);

    logic [CW-1:0] low_cnt_q;
    logic          at_limit;
    logic          about_to_fire;

    assign at_limit      = (low_cnt_q == LIMIT);
    assign about_to_fire = !level_in && (low_cnt_q == ARMPNT);

    // Count low cycles, clear on high, hold at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt_q <= '0;
        end else if (level_in) begin
            low_cnt_q <= '0;
        end else if (!at_limit) begin
            low_cnt_q <= low_cnt_q + CW'(1);
        end
    end

    // Register the single-cycle timeout pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fire_o <= 1'b0;
        end else begin
            fire_o <= about_to_fire;
        end
    end

endmodule

// File: rtl/fsk_hold_timer.sv
// Module: fsk_hold_timer
// Second stage. A retriggerable one-shot reloaded to HOLD_CYC by every
// first-stage pulse and counting down to zero otherwise. It is active while
// the count is non-zero. Assumes HOLD_CYC exceeds the pulse spacing of the
// slow tone, so a steady slow tone keeps it active without a gap.
module fsk_hold_timer #(
    parameter int unsigned HOLD_CYC = 1100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_in,
    output logic active_o
);

    import fsk_demod_pkg::*;

    localparam int unsigned CW = cnt_width(HOLD_CYC);
    localparam logic [CW-1:0] RELOAD = CW'(HOLD_CYC);

    logic [CW-1:0] hold_cnt_q;

    // Reload on a trigger, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_cnt_q <= '0;
        end else if (trig_in) begin
            hold_cnt_q <= RELOAD;
        end else if (hold_cnt_q != '0) begin
            hold_cnt_q <= hold_cnt_q - CW'(1);
        end
    end

    assign active_o = (hold_cnt_q != '0);

endmodule

// File: rtl/fsk_tone_demod.sv
// Module: fsk_tone_demod (top)
// Two-stage FSK demodulator: synchronizer, low-time one-shot and
// retriggerable hold one-shot. bit_out is high for the fast tone and low for
// the slow tone. Assumes the input is already sliced to a clean square wave.
// Timeouts are given in microseconds and converted with CLK_HZ.
module fsk_tone_demod #(
    parameter longint unsigned CLK_HZ      = 64'd1000000,
    parameter int unsigned     LOW_US      = 300,
    parameter int unsigned     HOLD_US     = 1100,
    parameter int unsigned     SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tone_in,
    output logic bit_out,
    output logic pulse_dbg
);

    import fsk_demod_pkg::*;

    localparam int unsigned LOW_CYC  = us_to_cycles(CLK_HZ, LOW_US);
    localparam int unsigned HOLD_CYC = us_to_cycles(CLK_HZ, HOLD_US);

    logic tone_sync;
    logic low_fire;
    logic hold_active;

    fsk_in_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (tone_in),
        .sync_out (tone_sync)
    );

    fsk_low_timer #(
        .LOW_CYC (LOW_CYC)
    ) u_low (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_in (tone_sync),
        .fire_o   (low_fire)
    );

    fsk_hold_timer #(
        .HOLD_CYC (HOLD_CYC)
    ) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig_in  (low_fire),
        .active_o (hold_active)
    );

    assign bit_out   = !hold_active;
    assign pulse_dbg = low_fire;

endmodule

// File: rtl/fsk_demod_chk.sv
// Module: fsk_demod_chk
// Assertion checker bound to fsk_tone_demod. It sees only the top ports.
// Assumes the default two-stage synchronizer.
module fsk_demod_chk #(
    parameter longint unsigned CLK_HZ  = 64'd1000000,
    parameter int unsigned     HOLD_US = 1100
) (
    input logic clk,
    input logic rst_n,
    input logic tone_in,
    input logic bit_out,
    input logic pulse_dbg
);

    import fsk_demod_pkg::*;

    localparam int unsigned HOLD_CYC = us_to_cycles(CLK_HZ, HOLD_US);
    localparam int unsigned GW       = cnt_width(HOLD_CYC + 1);
    localparam logic [GW-1:0] GMAX   = GW'(HOLD_CYC + 1);

    logic [GW-1:0] gap_q;
    logic          fired_in_run_q;

    // Cycles since the last pulse, saturating just past the hold window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q <= GMAX;
        end else if (pulse_dbg) begin
            gap_q <= GW'(1);
        end else if (gap_q != GMAX) begin
            gap_q <= gap_q + GW'(1);
        end
    end

    // Remember whether the current low interval has already fired.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fired_in_run_q <= 1'b0;
        end else if (tone_in) begin
            fired_in_run_q <= 1'b0;
        end else if (pulse_dbg) begin
            fired_in_run_q <= 1'b1;
        end
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk) !rst_n |=> (bit_out && !pulse_dbg));

    // R2
    pulse_after_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_dbg |-> (!$past(tone_in, 2) && !$past(tone_in, 3)));

    // R3
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_dbg |=> !pulse_dbg);

    // R4
    once_per_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_dbg |-> !fired_in_run_q);

    // R7
    hold_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_out == (gap_q > GW'(HOLD_CYC)));

endmodule

bind fsk_tone_demod fsk_demod_chk #(
    .CLK_HZ  (CLK_HZ),
    .HOLD_US (HOLD_US)
) u_demod_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tone_in   (tone_in),
    .bit_out   (bit_out),
    .pulse_dbg (pulse_dbg)
);

// File: tb/test_fsk_tone_demod.sv
// Scoreboard bench: driver tasks queue timed expectations of bit_out, and
// a monitor pops and compares them at the falling clock edge. CLK_HZ is set
// to 1 MHz so that one clock cycle models 1 us, while the simulated clock
// runs at 50 MHz.
module test_fsk_tone_demod;

    localparam int FAST_HALF = 208;
    localparam int SLOW_HALF = 416;

    typedef struct {
        int    t;
        logic  v;
        string req;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tone_in = 1'b1;
    logic bit_out;
    logic pulse_dbg;

    int   cyc = 0;
    int   pulses = 0;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    exp_t sb_q[$];

    always #10 clk = ~clk;

    fsk_tone_demod #(
        .CLK_HZ (64'd1000000)
    ) i_fsk_tone_demod (
        .clk       (clk),
        .rst_n     (rst_n),
        .tone_in   (tone_in),
        .bit_out   (bit_out),
        .pulse_dbg (pulse_dbg)
    );

    // Count cycles.
    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: count pulses and compare queued expectations.
    always @(negedge clk) begin
        if (pulse_dbg) pulses = pulses + 1;
        while (sb_q.size() > 0 && sb_q[0].t <= cyc) begin
            checks = checks + 1;
            if (bit_out !== sb_q[0].v) begin
                errors = errors + 1;
                $display("FAIL %s cycle %0d bit_out actual %b expected %b",
                         sb_q[0].req, cyc, bit_out, sb_q[0].v);
            end
            void'(sb_q.pop_front());
        end
    end

    task automatic check_val(input string req, input int act, input int exp_v);
        checks = checks + 1;
        if (act != exp_v) begin
            errors = errors + 1;
            $display("FAIL %s actual %0d expected %0d", req, act, exp_v);
        end
    endtask

    task automatic push(input int t, input logic v, input string req);
        exp_t e;
        e.t = t;
        e.v = v;
        e.req = req;
        sb_q.push_back(e);
    endtask

    task automatic hold_level(input logic v, input int n);
        tone_in = v;
        repeat (n) @(negedge clk);
    endtask

    // Slow tone for n cycles: bit_out low from start+400 to end+400 (R6, R7).
    task automatic send_space(input int n);
        int t0;
        int p0;
        t0 = cyc;
        p0 = pulses;
        for (int t = t0 + 400; t <= t0 + n * 2 * SLOW_HALF + 400; t += 200)
            push(t, 1'b0, "R6");
        for (int k = 0; k < n; k++) begin
            hold_level(1'b0, SLOW_HALF);
            hold_level(1'b1, SLOW_HALF);
        end
        check_val("R6 pulses per slow cycle", pulses - p0, n);
    endtask

    // Fast tone for n cycles: bit_out high from start+800 on, no pulses (R5).
    task automatic send_mark(input int n);
        int t0;
        int p0;
        t0 = cyc;
        p0 = pulses;
        for (int t = t0 + 800; t < t0 + n * 2 * FAST_HALF; t += 200)
            push(t, 1'b1, "R5");
        for (int k = 0; k < n; k++) begin
            hold_level(1'b0, FAST_HALF);
            hold_level(1'b1, FAST_HALF);
        end
        check_val("R5 no pulses on fast tone", pulses - p0, 0);
    endtask

    task automatic drain();
        while (sb_q.size() > 0) @(negedge clk);
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(negedge clk);
        if (!done) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int p0;
        int t0;
        repeat (5) @(negedge clk);
        // R1: outputs idle under reset.
        check_val("R1 bit_out in reset", int'(bit_out), 1);
        check_val("R1 pulse_dbg in reset", int'(pulse_dbg), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_val("R1 bit_out after reset", int'(bit_out), 1);
        check_val("R1 pulse_dbg after reset", int'(pulse_dbg), 0);

        // Frame-like sequence.
        send_mark(8);
        send_space(1);
        send_mark(2);
        send_space(3);
        send_mark(6);
        drain();

        // R2: just below threshold.
        p0 = pulses;
        t0 = cyc;
        push(t0 + 600, 1'b1, "R2");
        hold_level(1'b0, 290);
        hold_level(1'b1, 1500);
        check_val("R2 290-cycle low gives no pulse", pulses - p0, 0);
        drain();

        // R2/R7: just above threshold.
        p0 = pulses;
        t0 = cyc;
        push(t0 + 330, 1'b0, "R7");
        push(t0 + 1380, 1'b0, "R7");
        push(t0 + 1450, 1'b1, "R7");
        hold_level(1'b0, 320);
        hold_level(1'b1, 1500);
        check_val("R2 320-cycle low gives one pulse", pulses - p0, 1);
        drain();

        // R4: long steady low fires once, line recovers while still low.
        p0 = pulses;
        t0 = cyc;
        push(t0 + 400, 1'b0, "R4");
        push(t0 + 1600, 1'b1, "R4");
        push(t0 + 2950, 1'b1, "R4");
        hold_level(1'b0, 3000);
        check_val("R4 steady low single pulse", pulses - p0, 1);
        hold_level(1'b1, 300);
        drain();
        send_mark(4);
        drain();

        // R1: reset in the middle of a slow-tone bit.
        hold_level(1'b0, SLOW_HALF);
        check_val("R1 line low before mid-bit reset", int'(bit_out), 0);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check_val("R1 mid-bit reset bit_out", int'(bit_out), 1);
        check_val("R1 mid-bit reset pulse_dbg", int'(pulse_dbg), 0);
        tone_in = 1'b1;
        rst_n = 1'b1;
        repeat (2000) @(negedge clk);
        check_val("R1 stays idle after reset", int'(bit_out), 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule